// File: doc/BRIEF.md
# I2C Master SCL Clock Timer

This block turns a fast peripheral clock into the serial clock of an I2C master. A byte-level controller asks for clock pulses with a single `run` level. The timer then pulls SCL low for the low phase and lets it go for the high phase. The controller gets a strobe when the line has just been pulled low, which is the safe point to change SDA. It gets a second strobe when the line is first seen high, which is the point to sample SDA. START, STOP and the shifting of data stay with that controller.

Phase lengths come from a 12-bit period count P and two mode bits:

| Mode | High phase | Low phase | Ratio |
|------|-----------|-----------|-------|
| Standard | P cycles | P cycles | 1:1 |
| Fast, duty bit clear | P cycles | 2·P cycles | 1:2 |
| Fast, duty bit set | 9·P cycles | 16·P cycles | 9:16 |

When SCL is released, the high-phase counter may run for at most a programmed rise allowance while the line is still low. This lets a normal slow rising edge count toward the high time, so the period stays constant. If a target holds SCL low for longer than the allowance, the counter stops until the line is seen high. This is clock stretching.

The SCL input is sensed through a two-stage synchronizer. When the peripheral enable is low, the line is released and all timing state is cleared.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_drive_low`, `low_start` and `high_seen` are all 0. While `run` is 0 the line stays released.
- R2: In standard mode (`fast_sel`=0), the low phase lasts exactly P cycles. With no stretching and `rise_lim` ≥ 2, the high phase also lasts P cycles.
- R3: In fast mode with `duty_sel`=0, the low phase is 2·P cycles and the high phase is P cycles.
- R4: In fast mode with `duty_sel`=1, the low phase is 16·P cycles and the high phase is 9·P cycles.
- R5: In the high phase, the counter advances while SCL is sensed high, or while its value is below `rise_lim`. It holds otherwise. The phase ends only on a cycle where SCL is sensed high. The sensing latency is 2 cycles. So a target that holds SCL low for S cycles after release gives a high phase of max(T_high, S+2+T_high−`rise_lim`) cycles.
- R6: A slow rise that ends within the allowance (S+2 ≤ `rise_lim`) leaves the high phase at T_high. The SCL period is unchanged.
- R7: When `enable` is 0, `scl_drive_low` is 0 from the next cycle on, whatever `run` is. The timer starts a fresh low phase once `enable` returns with `run` set.
- R8: If `run` is 0 when a high phase ends, the line stays released and no further low phase starts.
- R9: `low_start` pulses for one cycle on the first cycle of each low phase. `high_seen` pulses once per high phase, on the first cycle SCL is sensed high. That is S+2 cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; low releases SCL and clears timing state |
| run | input | 1 | Byte controller requests clock pulses |
| period_cnt | input | 12 | Period count P in peripheral clock cycles |
| fast_sel | input | 1 | 1 selects fast-mode ratios |
| duty_sel | input | 1 | In fast mode, 1 selects the 9:16 ratio |
| rise_lim | input | 6 | Rise allowance in peripheral clock cycles |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain drive) |
| low_start | output | 1 | Strobe on the first cycle of a low phase |
| high_seen | output | 1 | Strobe on the first cycle SCL is sensed high |

## Verification
The bench measures phase widths in each of the three ratio modes. It uses a target model that holds the line low for a chosen time after release.

- **Wrong multipliers.** A design that swapped the fast-mode multipliers, or counted one cycle too few, would show wrong low or high widths.
- **Stretch handling.** A design that ignored the sensed line would end the high phase early under stretching. A design that did not let the counter run through the allowance would lengthen the period even for a slow but legal rise.
- **Enable and run.** Dropping `enable` must release the line at once. Dropping `run` must let the current pulse finish and then keep the line released; a design that got this wrong would keep clocking.
- **Strobe timing.** The sample strobe must come exactly two cycles after the line rises.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign line_out = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_phase_calc.sv
module i2c_scl_phase_calc #(
    parameter int PER_W = 12,
    localparam int CNT_W = PER_W + 4
) (
    input  logic [PER_W-1:0] period_cnt,
    input  logic             fast_sel,
    input  logic             duty_sel,
    output logic [CNT_W-1:0] t_high,
    output logic [CNT_W-1:0] t_low
);
    logic [CNT_W-1:0] p_ext;

    always_comb begin
        p_ext = {4'd0, period_cnt};
        if (!fast_sel) begin
            t_high = p_ext;
            t_low  = p_ext;
        end else if (!duty_sel) begin
            t_high = p_ext;
            t_low  = p_ext << 1;
        end else begin
            t_high = (p_ext << 3) + p_ext;
            t_low  = p_ext << 4;
        end
    end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int PER_W       = 12,
    parameter int RISE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [PER_W-1:0] period_cnt,
    input  logic             fast_sel,
    input  logic             duty_sel,
    input  logic [RISE_W-1:0] rise_lim,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             low_start,
    output logic             high_seen
);
    localparam int CNT_W = PER_W + 4;

    typedef struct packed {
        phase_e           st;
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } tstate_t;

    tstate_t          cur_q, nxt_d;
    logic [CNT_W-1:0] t_high, t_low;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] rise_ext;
    logic             scl_hi;

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (scl_in),
        .line_out (scl_hi)
    );

    i2c_scl_phase_calc #(.PER_W(PER_W)) calc_i (
        .period_cnt (period_cnt),
        .fast_sel   (fast_sel),
        .duty_sel   (duty_sel),
        .t_high     (t_high),
        .t_low      (t_low)
    );

    assign cnt_inc  = {1'b0, cur_q.cnt} + 1'b1;
    assign rise_ext = CNT_W'(rise_lim);

    always_comb begin
        nxt_d = cur_q;
        if (!enable) begin
            nxt_d.st   = PH_IDLE;
            nxt_d.cnt  = '0;
            nxt_d.seen = 1'b0;
        end else begin
            unique case (cur_q.st)
                PH_IDLE: begin
                    if (run) begin
                        nxt_d.st   = PH_LOW;
                        nxt_d.cnt  = '0;
                        nxt_d.seen = 1'b0;
                    end
                end
                PH_LOW: begin
                    if (cnt_inc >= {1'b0, t_low}) begin
                        nxt_d.st   = PH_HIGH;
                        nxt_d.cnt  = '0;
                        nxt_d.seen = 1'b0;
                    end else begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
                PH_HIGH: begin
                    if (scl_hi) nxt_d.seen = 1'b1;
                    if ((cnt_inc >= {1'b0, t_high}) && scl_hi) begin
                        nxt_d.st   = run ? PH_LOW : PH_IDLE;
                        nxt_d.cnt  = '0;
                        nxt_d.seen = 1'b0;
                    end else if ((cnt_inc < {1'b0, t_high}) &&
                                 (scl_hi || (cur_q.cnt < rise_ext))) begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
                default: begin
                    nxt_d.st   = PH_IDLE;
                    nxt_d.cnt  = '0;
                    nxt_d.seen = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= PH_IDLE;
            cur_q.cnt  <= '0;
            cur_q.seen <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_drive_low = (cur_q.st == PH_LOW);
    assign low_start     = (cur_q.st == PH_LOW) && (cur_q.cnt == '0);
    assign high_seen     = (cur_q.st == PH_HIGH) && scl_hi && !cur_q.seen;

    AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low) else $error("enable low kept SCL driven"); // R7

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cur_q.st == PH_LOW && cnt_inc < {1'b0, t_low})
        |=> (cur_q.st == PH_LOW && cur_q.cnt == $past(cur_q.cnt) + 1'b1))
        else $error("low phase cut short"); // R2

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cur_q.st == PH_HIGH && !scl_hi && cur_q.cnt >= rise_ext)
        |=> (cur_q.st == PH_HIGH && cur_q.cnt == $past(cur_q.cnt)))
        else $error("high counter moved during stretch"); // R5

    AST_NO_LOW_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PH_HIGH && !scl_hi) |=> (cur_q.st != PH_LOW))
        else $error("high phase ended with line low"); // R5

    AST_SEEN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        high_seen |=> !high_seen) else $error("sample strobe repeated"); // R9
endmodule

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic [11:0] period_cnt = 12'd10;
    logic        fast_sel = 1'b0;
    logic        duty_sel = 1'b0;
    logic [5:0]  rise_lim = 6'd4;
    logic        scl_in;
    logic        scl_drive_low, low_start, high_seen;

    int n_run = 0;
    int n_fail = 0;
    int stretch_len = 0;
    int rel_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (scl_drive_low) rel_cnt <= 0;
        else               rel_cnt <= rel_cnt + 1;
    end

    assign scl_in = !scl_drive_low && (rel_cnt >= stretch_len);

    i2c_scl_timer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .period_cnt(period_cnt), .fast_sel(fast_sel), .duty_sel(duty_sel),
        .rise_lim(rise_lim), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .low_start(low_start), .high_seen(high_seen)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(output int lo, output int hi, output int seen_at,
                           output int lstb);
        @(negedge clk);
        while (scl_drive_low) @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        lo = 0; hi = 0; seen_at = -1; lstb = 0;
        while (scl_drive_low) begin
            if (low_start) lstb++;
            lo++;
            @(negedge clk);
        end
        while (!scl_drive_low) begin
            if (high_seen && seen_at < 0) seen_at = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 drive after reset", int'(scl_drive_low), 0);
        chk("R1 strobes after reset", int'(low_start | high_seen), 0);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 idle without run", int'(scl_drive_low), 0);
    endtask

    task automatic t_standard();
        int lo, hi, s, ls;
        fast_sel = 0; duty_sel = 0; period_cnt = 12'd10; rise_lim = 6'd4;
        stretch_len = 0; run = 1'b1;
        measure(lo, hi, s, ls);
        chk("R2 standard low", lo, 10);
        chk("R2 standard high", hi, 10);
        chk("R9 low strobe count", ls, 1);
        chk("R9 sample strobe offset", s, 2);
    endtask

    task automatic t_fast0();
        int lo, hi, s, ls;
        fast_sel = 1; duty_sel = 0; period_cnt = 12'd5;
        measure(lo, hi, s, ls);
        chk("R3 fast low", lo, 10);
        chk("R3 fast high", hi, 5);
    endtask

    task automatic t_fast1();
        int lo, hi, s, ls;
        fast_sel = 1; duty_sel = 1; period_cnt = 12'd2;
        measure(lo, hi, s, ls);
        chk("R4 duty low", lo, 32);
        chk("R4 duty high", hi, 18);
    endtask

    task automatic t_stretch();
        int lo, hi, s, ls;
        fast_sel = 0; duty_sel = 0; period_cnt = 12'd10; rise_lim = 6'd4;
        stretch_len = 10;
        measure(lo, hi, s, ls);
        chk("R5 stretch low", lo, 10);
        chk("R5 stretched high", hi, 18);
        chk("R9 strobe after stretch", s, 12);
    endtask

    task automatic t_rise();
        int lo, hi, s, ls;
        rise_lim = 6'd6; stretch_len = 3;
        measure(lo, hi, s, ls);
        chk("R6 compensated high", hi, 10);
        chk("R6 low unchanged", lo, 10);
        stretch_len = 0;
    endtask

    task automatic t_enable();
        int lowseen = 0;
        @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R7 release after enable drop", int'(scl_drive_low), 0);
        repeat (40) begin
            @(negedge clk);
            if (scl_drive_low) lowseen++;
        end
        chk("R7 stays released", lowseen, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R7 restart low phase", int'(low_start), 1);
    endtask

    task automatic t_run_stop();
        int lows = 0;
        @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        run = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (low_start) lows++;
        end
        chk("R8 no further low phase", lows, 0);
        chk("R8 line released", int'(scl_drive_low), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_standard();
        t_fast0();
        t_fast1();
        t_stretch();
        t_rise();
        t_enable();
        t_run_stop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule